// File: doc/BRIEF.md
# Converter Serial Control Front End

This block is the digital serial face of a multi-channel sigma-delta converter. A host talks to it as a serial slave over a select line, a serial clock, a serial data input and one serial data output. Every access begins with a command byte. The command says whether the host reads or writes, which internal register is the target, and whether automatic streaming should be turned on. The block holds a status register, a mode register and a conversion result register. A stubbed modulator supplies a conversion-done strobe and a result word.

The single output line does two jobs. While the host is shifting out a register, it carries that register's data. At every other time while the block is selected, it carries an active-low flag that says an unread conversion is waiting. There are three ways of running. Continuous conversion is the power-up default. Single conversion takes one result and then puts the modulator into standby. Streaming sends each new result out on the output line with no command in front of it.

The serial lines are treated as slow inputs. They are synchronised to the system clock and their edges are found there. Input data is sampled on rising serial-clock edges. Output data moves on falling edges.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset the mode field holds 00 (continuous), `mod_run` is high, the ready flag is high (nothing unread), and `sdo` is high. Register addresses: status = 0, mode = 1, result = 3.
- R2: While the modulator runs, each `conv_done` captures `conv_word` and drives the ready flag low. With `sel_n` low and no transfer in progress, `sdo` follows the ready flag.
- R3: The command 0x58 (read of address 3) is followed by 24 bits of the captured word on `sdo`, MSB first, each bit valid from a falling `ser_clk` edge to the next rising edge. Once all 24 bits are out, the ready flag returns high.
- R4: In continuous and single modes the result register can be read again after the ready flag has returned high. The read repeats the same word.
- R5: The command 0x40 reads 8 status bits: bit 7 is the active-low ready flag, bits 1:0 are the mode field, and all other bits are 0.
- R6: The command 0x08 followed by one data byte writes that byte's bits 1:0 to the mode field. The command 0x48 reads the mode byte back, with bits 7:2 as 0. Mode 00 is continuous, 01 is single, and 10 or 11 is standby. `mod_run` is high only for 00 and 01.
- R7: In single mode the first accepted conversion sets the mode field to 10 and drops `mod_run`. In standby `conv_done` is ignored: the result register keeps its old value and the ready flag does not change.
- R8: A command of 0x5C (a read of address 3 with bit 2 set) turns on streaming. Each later conversion is placed on `sdo` with its MSB at once, and 24 clocks read it out with no command. After the read the ready flag is high, and the same word is never presented twice.
- R9: In streaming, a new conversion abandons any read that has not finished and restarts the output at the new word's MSB.
- R10: In streaming, every byte on `sdi` other than 0x58 is ignored (including register writes). The byte 0x58, aligned to 8-bit groups counted from select falling or from the last conversion, ends streaming.
- R11: 32 consecutive 1s sampled on `sdi` with `sel_n` low return the block to its reset state in any mode, streaming included. The captured word is kept.
- R12: A command byte with bit 7 set, or with bits 1:0 not 00, is ignored. The next byte is decoded as a fresh command.
- R13: With `sel_n` high, `sdo` is high and any partial frame is dropped. In streaming, a falling `sel_n` while an unread word is waiting presents that word's MSB on `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low slave select (may be tied low) |
| ser_clk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data input, sampled on rising `ser_clk` |
| sdo | output | 1 | Serial data out, or the active-low ready flag between transfers |
| conv_done | input | 1 | One-cycle strobe from the modulator stub |
| conv_word | input | DATA_W | Conversion result offered with `conv_done` |
| mod_run | output | 1 | High while the modulator should convert |

## Verification
The bench sweeps every mode code and a range of arithmetic result words, including all-zeros and all-ones. It also covers the cases where timing decides the outcome. One is a conversion landing in the middle of a streamed read: a design that ignores it returns a mix of old and new bits. Another is a first falling clock after a streamed load: a design that shifts on it loses the MSB. Re-arming the same word on a select edge is also tested, since a faulty design would stream one result twice. An invalid command must not be taken as a write to the mode register, and 32 ones must clear streaming even while register access is blocked; a design that gets either wrong leaves the mode readback or the status read wrong.

// File: rtl/adc_sif_pkg.sv
// Shared constants and types for the converter serial front end.
// Assumes a 3-bit register address field in the command byte.
package adc_sif_pkg;

    // Frame engine phases
    typedef enum logic [2:0] {
        PH_CMD     = 3'd0,  // collecting a command byte
        PH_WR      = 3'd1,  // collecting a write data byte
        PH_RD_ARM  = 3'd2,  // waiting for the falling edge that loads the shifter
        PH_RD      = 3'd3,  // shifting out a register
        PH_CR_IDLE = 3'd4,  // streaming, nothing being shifted
        PH_CR_RD   = 3'd5   // streaming, word being shifted
    } phase_e;

    localparam logic [2:0] ADDR_STAT = 3'd0;
    localparam logic [2:0] ADDR_MODE = 3'd1;
    localparam logic [2:0] ADDR_DATA = 3'd3;

    localparam logic [1:0] MODE_CONT    = 2'b00;
    localparam logic [1:0] MODE_SINGLE  = 2'b01;
    localparam logic [1:0] MODE_STANDBY = 2'b10;

    localparam logic [7:0] CMD_STREAM_EXIT = 8'h58;

endpackage

// File: rtl/adc_pin_sync.sv
// Synchronises the three serial input pins to clk and derives one-cycle
// rising/falling serial-clock pulses and a select-fall pulse.
// Assumes ser_clk is much slower than clk (several clk cycles per half period).
module adc_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic sel_n,
    input  logic sdi,
    output logic clk_rise,
    output logic clk_fall,
    output logic sel_n_s,
    output logic sel_fall,
    output logic sdi_s
);
    // bit 2 = ser_clk, bit 1 = sel_n, bit 0 = sdi
    localparam logic [2:0] IDLE_PINS = 3'b110;

    logic [2:0] stage_q [SYNC_STAGES];
    logic       sclk_prev_q;
    logic       sel_prev_q;

    for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            // Capture the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= IDLE_PINS;
                else        stage_q[0] <= {ser_clk, sel_n, sdi};
            end
        end else begin : g_next
            // Pass the pins further down the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[k] <= IDLE_PINS;
                else        stage_q[k] <= stage_q[k-1];
            end
        end
    end

    // Remember last synchronised clock and select levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b1;
            sel_prev_q  <= 1'b1;
        end else begin
            sclk_prev_q <= stage_q[SYNC_STAGES-1][2];
            sel_prev_q  <= stage_q[SYNC_STAGES-1][1];
        end
    end

    assign clk_rise = stage_q[SYNC_STAGES-1][2] & ~sclk_prev_q;
    assign clk_fall = ~stage_q[SYNC_STAGES-1][2] & sclk_prev_q;
    assign sel_n_s  = stage_q[SYNC_STAGES-1][1];
    assign sel_fall = ~stage_q[SYNC_STAGES-1][1] & sel_prev_q;
    assign sdi_s    = stage_q[SYNC_STAGES-1][0];

endmodule

// File: rtl/adc_reg_bank.sv
// Holds the mode field, the ready flag and the captured conversion word.
// Presents the register selected by rd_addr left-aligned with its length.
// Assumes DATA_W > 8 and one-cycle strobes from the frame engine.
module adc_reg_bank
    import adc_sif_pkg::*;
#(
    parameter int DATA_W = 24,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    input  logic [2:0]        rd_addr,
    input  logic              rd_start,
    input  logic              rd_done,
    output logic [DATA_W-1:0] rd_word,
    output logic [CNT_W-1:0]  rd_len,
    output logic              fresh_n,
    output logic              new_data,
    output logic              mod_run
);
    localparam int PAD_W = DATA_W - 8;

    logic [1:0]        mode_q;
    logic [DATA_W-1:0] word_q;
    logic              fresh_n_q;
    logic              newer_q;   // a capture happened after the shifter was loaded
    logic              new_data_q;
    logic              accept;

    assign mod_run = ~mode_q[1];
    assign accept  = conv_done & mod_run;

    // Register updates: captures, mode changes and the ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_CONT;
            word_q     <= '0;
            fresh_n_q  <= 1'b1;
            newer_q    <= 1'b0;
            new_data_q <= 1'b0;
        end else if (soft_rst) begin
            mode_q     <= MODE_CONT;
            fresh_n_q  <= 1'b1;
            newer_q    <= 1'b0;
            new_data_q <= 1'b0;
        end else begin
            new_data_q <= accept;
            if (accept) word_q <= conv_word;
            if (mode_we)                           mode_q <= mode_wdata;
            else if (accept && mode_q == MODE_SINGLE) mode_q <= MODE_STANDBY;
            if (accept)                      fresh_n_q <= 1'b0;
            else if (rd_done && !newer_q)    fresh_n_q <= 1'b1;
            if (accept)        newer_q <= 1'b1;
            else if (rd_start) newer_q <= 1'b0;
        end
    end

    // Read mux: short registers are left-aligned in the shift word
    always_comb begin
        rd_len = CNT_W'(8);
        unique case (rd_addr)
            ADDR_STAT: rd_word = {fresh_n_q, 5'b00000, mode_q, {PAD_W{1'b0}}};
            ADDR_MODE: rd_word = {6'b000000, mode_q, {PAD_W{1'b0}}};
            ADDR_DATA: begin
                rd_word = word_q;
                rd_len  = CNT_W'(DATA_W);
            end
            default:   rd_word = '0;
        endcase
    end

    assign fresh_n  = fresh_n_q;
    assign new_data = new_data_q;

    AST_READY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !soft_rst |=> !fresh_n_q);  // R2
    AST_SINGLE_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !soft_rst && !mode_we && mode_q == MODE_SINGLE |=> mode_q == MODE_STANDBY);  // R7
    AST_STANDBY_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_run |=> $stable(word_q));  // R7
    AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> mode_q == MODE_CONT && fresh_n_q);  // R11

endmodule

// File: rtl/adc_frame_engine.sv
// Serial frame engine: decodes command bytes, collects write data, shifts
// register contents out, runs streaming mode and watches for 32 ones.
// Assumes synchronised inputs with one-cycle edge pulses from adc_pin_sync.
module adc_frame_engine
    import adc_sif_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int ONES_LIMIT = 32,
    localparam int CNT_W  = $clog2(DATA_W + 1),
    localparam int ONES_W = $clog2(ONES_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_rise,
    input  logic              clk_fall,
    input  logic              sel_n_s,
    input  logic              sel_fall,
    input  logic              sdi_s,
    input  logic              fresh_n,
    input  logic              new_data,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [CNT_W-1:0]  rd_len,
    output logic [2:0]        rd_addr,
    output logic              mode_we,
    output logic [1:0]        mode_wdata,
    output logic              rd_start,
    output logic              rd_done,
    output logic              soft_rst,
    output logic              sdo
);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(DATA_W - 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [CNT_W-1:0]  len_q;
    logic [6:0]        cmd_sh_q;
    logic              wr_prev_q;
    logic [DATA_W-1:0] tx_q;
    logic              rose_q;     // a rising edge has passed since the last shift
    logic [2:0]        addr_q;
    logic              stream_q;
    logic [2:0]        ex_cnt_q;
    logic [6:0]        ex_sh_q;
    logic [ONES_W-1:0] ones_q;
    logic              mode_we_q, rd_start_q, rd_done_q, soft_q;
    logic [1:0]        mode_wdata_q;

    logic [7:0] cmd_byte;
    logic [7:0] ex_byte;
    logic       cmd_ok;
    logic       ones_hit;
    logic       exit_hit;
    logic       stream_load;

    assign cmd_byte    = {cmd_sh_q, sdi_s};
    assign ex_byte     = {ex_sh_q, sdi_s};
    assign cmd_ok      = !cmd_byte[7] && cmd_byte[1:0] == 2'b00;
    assign ones_hit    = !sel_n_s && clk_rise && sdi_s && ones_q == ONES_W'(ONES_LIMIT - 1);
    assign exit_hit    = stream_q && clk_rise && ex_cnt_q == 3'd7 && ex_byte == CMD_STREAM_EXIT;
    assign stream_load = stream_q && (new_data || (sel_fall && !fresh_n));
    assign rd_addr     = stream_q ? ADDR_DATA : addr_q;

    // Frame sequencing, shifting, streaming control and the ones watchdog
    always_ff @(posedge clk) begin
        if (!rst_n || ones_hit) begin
            phase_q      <= PH_CMD;
            bit_cnt_q    <= '0;
            len_q        <= CNT_W'(8);
            cmd_sh_q     <= '0;
            wr_prev_q    <= 1'b0;
            tx_q         <= '0;
            rose_q       <= 1'b0;
            addr_q       <= ADDR_STAT;
            stream_q     <= 1'b0;
            ex_cnt_q     <= '0;
            ex_sh_q      <= '0;
            ones_q       <= '0;
            mode_we_q    <= 1'b0;
            mode_wdata_q <= MODE_CONT;
            rd_start_q   <= 1'b0;
            rd_done_q    <= 1'b0;
            soft_q       <= rst_n;
        end else begin
            mode_we_q  <= 1'b0;
            rd_start_q <= 1'b0;
            rd_done_q  <= 1'b0;
            soft_q     <= 1'b0;

            if (sel_n_s)       ones_q <= '0;
            else if (clk_rise) ones_q <= sdi_s ? ones_q + ONES_W'(1) : '0;

            if (sel_n_s) begin
                phase_q   <= stream_q ? PH_CR_IDLE : PH_CMD;
                bit_cnt_q <= '0;
                ex_cnt_q  <= '0;
                rose_q    <= 1'b0;
            end else if (stream_load) begin
                tx_q       <= rd_word;
                phase_q    <= PH_CR_RD;
                bit_cnt_q  <= '0;
                ex_cnt_q   <= '0;
                rose_q     <= 1'b0;
                rd_start_q <= 1'b1;
            end else begin
                if (stream_q && clk_rise) begin
                    ex_sh_q  <= ex_byte[6:0];
                    ex_cnt_q <= ex_cnt_q + 3'd1;
                end
                unique case (phase_q)
                    PH_CMD: if (clk_rise) begin
                        cmd_sh_q  <= cmd_byte[6:0];
                        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        if (bit_cnt_q == LAST_BIT) begin
                            bit_cnt_q <= '0;
                            if (cmd_ok) begin
                                addr_q <= cmd_byte[5:3];
                                if (!cmd_byte[6]) begin
                                    phase_q <= PH_WR;
                                end else if (cmd_byte[5:3] == ADDR_DATA && cmd_byte[2]) begin
                                    stream_q <= 1'b1;
                                    ex_cnt_q <= '0;
                                    phase_q  <= PH_CR_IDLE;
                                end else begin
                                    phase_q <= PH_RD_ARM;
                                end
                            end
                        end
                    end
                    PH_WR: if (clk_rise) begin
                        wr_prev_q <= sdi_s;
                        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        if (bit_cnt_q == LAST_BIT) begin
                            bit_cnt_q    <= '0;
                            phase_q      <= PH_CMD;
                            mode_we_q    <= (addr_q == ADDR_MODE);
                            mode_wdata_q <= {wr_prev_q, sdi_s};
                        end
                    end
                    PH_RD_ARM: if (clk_fall) begin
                        tx_q       <= rd_word;
                        len_q      <= rd_len;
                        bit_cnt_q  <= '0;
                        rose_q     <= 1'b0;
                        phase_q    <= PH_RD;
                        rd_start_q <= (addr_q == ADDR_DATA);
                    end
                    PH_RD: begin
                        if (clk_rise) begin
                            rose_q <= 1'b1;
                            if (bit_cnt_q == len_q - CNT_W'(1)) begin
                                bit_cnt_q <= '0;
                                phase_q   <= PH_CMD;
                                rd_done_q <= (addr_q == ADDR_DATA);
                            end else begin
                                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                            end
                        end else if (clk_fall && rose_q) begin
                            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                            rose_q <= 1'b0;
                        end
                    end
                    PH_CR_IDLE: ;
                    PH_CR_RD: begin
                        if (clk_rise) begin
                            rose_q <= 1'b1;
                            if (bit_cnt_q == LAST_WORD) begin
                                bit_cnt_q <= '0;
                                phase_q   <= PH_CR_IDLE;
                                rd_done_q <= 1'b1;
                            end else begin
                                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                            end
                        end else if (clk_fall && rose_q) begin
                            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                            rose_q <= 1'b0;
                        end
                    end
                    default: phase_q <= PH_CMD;
                endcase
                if (exit_hit) begin
                    stream_q  <= 1'b0;
                    phase_q   <= PH_CMD;
                    bit_cnt_q <= '0;
                end
            end
        end
    end

    // Output line: data while shifting, ready flag otherwise, high when deselected
    always_comb begin
        if (sel_n_s)                                    sdo = 1'b1;
        else if (phase_q == PH_RD || phase_q == PH_CR_RD) sdo = tx_q[DATA_W-1];
        else                                            sdo = fresh_n;
    end

    assign mode_we    = mode_we_q;
    assign mode_wdata = mode_wdata_q;
    assign rd_start   = rd_start_q;
    assign rd_done    = rd_done_q;
    assign soft_rst   = soft_q;

    AST_STREAM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        stream_q && new_data && !sel_n_s && !ones_hit |=> phase_q == PH_CR_RD && bit_cnt_q == '0);  // R9
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> phase_q == PH_CMD || phase_q == PH_CR_IDLE);  // R13
    AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_CMD && clk_rise && !sel_n_s && bit_cnt_q == LAST_BIT && !cmd_ok && !ones_hit
        |=> phase_q == PH_CMD);  // R12
    AST_ONES_CLEAR_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        ones_hit |=> !stream_q && phase_q == PH_CMD);  // R11

endmodule

// File: rtl/adc_serial_ctrl.sv
// Top of the converter serial front end: pin synchroniser, frame engine and
// register bank. Assumes ser_clk half periods of several clk cycles.
module adc_serial_ctrl #(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int ONES_LIMIT  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              ser_clk,
    input  logic              sdi,
    output logic              sdo,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_word,
    output logic              mod_run
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic              clk_rise, clk_fall, sel_n_s, sel_fall, sdi_s;
    logic              fresh_n, new_data;
    logic [DATA_W-1:0] rd_word;
    logic [CNT_W-1:0]  rd_len;
    logic [2:0]        rd_addr;
    logic              mode_we, rd_start, rd_done, soft_rst;
    logic [1:0]        mode_wdata;

    adc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n), .sdi(sdi),
        .clk_rise(clk_rise), .clk_fall(clk_fall), .sel_n_s(sel_n_s),
        .sel_fall(sel_fall), .sdi_s(sdi_s)
    );

    adc_frame_engine #(.DATA_W(DATA_W), .ONES_LIMIT(ONES_LIMIT)) u_engine (
        .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .clk_fall(clk_fall),
        .sel_n_s(sel_n_s), .sel_fall(sel_fall), .sdi_s(sdi_s),
        .fresh_n(fresh_n), .new_data(new_data), .rd_word(rd_word), .rd_len(rd_len),
        .rd_addr(rd_addr), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .rd_start(rd_start), .rd_done(rd_done), .soft_rst(soft_rst), .sdo(sdo)
    );

    adc_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .conv_done(conv_done), .conv_word(conv_word),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .rd_addr(rd_addr),
        .rd_start(rd_start), .rd_done(rd_done), .rd_word(rd_word), .rd_len(rd_len),
        .fresh_n(fresh_n), .new_data(new_data), .mod_run(mod_run)
    );

endmodule

// File: tb/tb_adc_serial_ctrl.sv
module tb_adc_serial_ctrl;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic        sdi = 1'b0;
    logic        conv_done = 1'b0;
    logic [23:0] conv_word = '0;
    logic        sdo, mod_run;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    adc_serial_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .sdi(sdi),
        .sdo(sdo), .conv_done(conv_done), .conv_word(conv_word), .mod_run(mod_run)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tx_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            ser_clk = 1'b0; wait_clk(HALF);
            ser_clk = 1'b1; wait_clk(HALF);
        end
        sdi = 1'b0;
        wait_clk(4);
    endtask

    task automatic rx_bits(input int n, output logic [31:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b0; wait_clk(HALF);
            v = {v[30:0], sdo};
            ser_clk = 1'b1; wait_clk(HALF);
        end
        wait_clk(6);
    endtask

    task automatic rd_reg(input logic [7:0] cmd, input int n, output logic [31:0] v);
        tx_byte(cmd);
        rx_bits(n, v);
    endtask

    task automatic convert(input logic [23:0] w);
        conv_word = w; conv_done = 1'b1;
        wait_clk(1);
        conv_done = 1'b0;
        wait_clk(10);
    endtask

    task automatic reselect();
        sel_n = 1'b1; wait_clk(10);
        sel_n = 1'b0; wait_clk(10);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [23:0] w, w1;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(10);
        // R1: reset state
        chk("R1 sdo deselected", 32'(sdo), 32'd1);
        chk("R1 mod_run", 32'(mod_run), 32'd1);
        sel_n = 1'b0; wait_clk(10);
        chk("R1 ready flag idle", 32'(sdo), 32'd1);
        rd_reg(8'h40, 8, v);
        chk("R1 R5 status after reset", v, 32'h80);

        // R2 R3 R4 R5: capture, flag, read, re-read
        convert(24'hA53C96);
        chk("R2 flag low", 32'(sdo), 32'd0);
        rd_reg(8'h40, 8, v);
        chk("R5 status ready", v, 32'h00);
        rd_reg(8'h58, 24, v);
        chk("R3 word", v, 32'hA53C96);
        chk("R3 flag high after read", 32'(sdo), 32'd1);
        rd_reg(8'h58, 24, v);
        chk("R4 re-read", v, 32'hA53C96);

        // R2 R3: sweep of arithmetic words including extremes
        for (int i = 0; i < 10; i++) begin
            w = (i == 8) ? 24'h000000 : (i == 9) ? 24'hFFFFFF : 24'(i * 32'h2F1B37 + 32'h0A0A05);
            convert(w);
            chk("R2 sweep flag", 32'(sdo), 32'd0);
            rd_reg(8'h58, 24, v);
            chk("R3 sweep word", v, 32'(w));
            chk("R3 sweep flag high", 32'(sdo), 32'd1);
        end

        // R6: every mode code with noise in upper bits
        for (int m = 0; m < 4; m++) begin
            tx_byte(8'h08);
            tx_byte({6'b101101, 2'(m)});
            rd_reg(8'h48, 8, v);
            chk("R6 mode readback", v, 32'(m));
            chk("R6 mod_run", 32'(mod_run), (m < 2) ? 32'd1 : 32'd0);
            rd_reg(8'h40, 8, v);
            chk("R5 status mode", v, 32'h80 | 32'(m));
        end

        // R7: single conversion then standby
        tx_byte(8'h08); tx_byte(8'h01);
        w1 = 24'h5E17C3;
        convert(w1);
        chk("R7 flag low", 32'(sdo), 32'd0);
        chk("R7 mod_run dropped", 32'(mod_run), 32'd0);
        rd_reg(8'h48, 8, v);
        chk("R7 mode standby", v, 32'h02);
        rd_reg(8'h58, 24, v);
        chk("R7 single word", v, 32'(w1));
        convert(24'h123456);
        chk("R7 standby flag unchanged", 32'(sdo), 32'd1);
        rd_reg(8'h58, 24, v);
        chk("R7 standby keeps word", v, 32'(w1));

        // R12: invalid commands ignored
        tx_byte(8'h88);
        rd_reg(8'h48, 8, v);
        chk("R12 bit7 cmd ignored", v, 32'h02);
        tx_byte(8'h09);
        rd_reg(8'h48, 8, v);
        chk("R12 low bits cmd ignored", v, 32'h02);

        // R8: streaming
        tx_byte(8'h08); tx_byte(8'h00);
        tx_byte(8'h5C);
        convert(24'hC0FFEE);
        rx_bits(24, v);
        chk("R8 streamed word", v, 32'hC0FFEE);
        chk("R8 flag high", 32'(sdo), 32'd1);
        reselect();
        rx_bits(24, v);
        chk("R8 read only once", v, 32'hFFFFFF);

        // R9: new conversion abandons partial read
        convert(24'h3A3A3A);
        rx_bits(10, v);
        convert(24'h81C4E2);
        rx_bits(24, v);
        chk("R9 restart on new word", v, 32'h81C4E2);

        // R13: deselected output, select fall presents MSB
        sel_n = 1'b1; wait_clk(10);
        convert(24'h96F00D);
        chk("R13 deselected sdo high", 32'(sdo), 32'd1);
        sel_n = 1'b0; wait_clk(10);
        rx_bits(24, v);
        chk("R13 select fall word", v, 32'h96F00D);

        // R10: other commands blocked, exit byte leaves streaming
        reselect();
        tx_byte(8'h08); tx_byte(8'h02);
        tx_byte(8'h58);
        rd_reg(8'h48, 8, v);
        chk("R10 write blocked", v, 32'h00);
        chk("R10 mod_run kept", 32'(mod_run), 32'd1);

        // R11: 32 ones restore reset state
        tx_byte(8'h08); tx_byte(8'h02);
        chk("R11 standby set", 32'(mod_run), 32'd0);
        for (int k = 0; k < 4; k++) tx_byte(8'hFF);
        chk("R11 mod_run restored", 32'(mod_run), 32'd1);
        rd_reg(8'h40, 8, v);
        chk("R11 status default", v, 32'h80);
        tx_byte(8'h5C);
        for (int k = 0; k < 4; k++) tx_byte(8'hFF);
        rd_reg(8'h40, 8, v);
        chk("R11 streaming cleared", v, 32'h80);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule